// File: doc/BRIEF.md
# TU-12 Pointer State Monitor

This block supervises the pointer of a single TU-12 tributary. Once per 500 µs multiframe it takes the two pointer bytes (first and second pointer byte) out of an incoming byte stream. A pair of position strobes travelling with the data marks those two bytes. The block sorts each pointer into one of three classes: a usable offset, the all-ones alarm pattern, or garbage. It then runs a persistence state machine whose runs are counted in whole multiframes.

The machine has three states: normal, alarm-indication (AIS) and loss-of-pointer (LOP). The AIS and LOP states are presented as status bits. Each alarm also has a sticky interrupt bit that is set on the alarm's rising edge and cleared by reading it. An enable register gates the sticky bits onto a single interrupt pin. A small synchronous register port gives access to status, sticky bits and enables.

The byte input is a valid/ready stream. The block never applies back-pressure: `in_ready` is low while reset is held and high from the first clock after reset is released. A byte counts only on a cycle with `in_valid` and `in_ready` both high. Data, strobes and valid must stay stable until accepted.

Top module: `tu12_ptr_mon`

## Requirements
- R1: After reset, the status, sticky and enable registers all read 0, `irq` is 0, and `in_ready` is 1 from the first clock after reset release.
- R2: The pointer word is {first byte, second byte}. Bits 15:12 are the new-data flag and bits 9:0 are the offset; bits 11:10 are ignored. The word is valid when the flag is 4'b0110 and the offset is at most 139. It is the AIS pattern when both bytes are 8'hFF. Every other value is invalid.
- R3: The AIS state is entered on the 8th consecutive AIS multiframe, from normal or from LOP. Status register (address 0) bit 0 is 1 in the AIS state and is readable the cycle after the second pointer byte is accepted.
- R4: The LOP state is entered on the 8th consecutive invalid multiframe, from normal or from AIS. Status register bit 1 is 1 in the LOP state.
- R5: LOP is left only after 8 consecutive valid multiframes, which lead to normal, or 8 consecutive AIS multiframes, which lead to AIS.
- R6: AIS is left for normal after 8 consecutive valid multiframes.
- R7: A multiframe of one class resets the run counters of the other two classes to zero.
- R8: Sticky register (address 1; bit 0 AIS, bit 1 LOP) bits set on the rising edge of the alarm. A read of address 1 clears them. A bit does not set again while its alarm stays active.
- R9: If an alarm rises in the same cycle as a read of address 1, the bit ends up set. The read returns the old value.
- R10: `irq` is the OR of the sticky bits ANDed with the enable register (address 2, read/write, same bit order). Writes to addresses 0 and 1 have no effect.
- R11: A second pointer byte is evaluated only when a first pointer byte has been accepted since the last evaluation. Bytes with `in_valid` low are not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte stream valid |
| in_ready | output | 1 | Byte stream ready, high outside reset |
| in_data | input | 8 | Stream byte |
| in_mark_v1 | input | 1 | Marks the first pointer byte |
| in_mark_v2 | input | 1 | Marks the second pointer byte |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 2 | Register address: 0 status, 1 sticky, 2 enable |
| reg_wdata | input | 2 | Write data |
| reg_rdata | output | 2 | Read data for the addressed register, combinational |
| irq | output | 1 | Interrupt pin |

## Verification
Two things can land on the same clock edge: an alarm becoming active and software reading the sticky register to clear it. The bench lines these up by issuing the sticky-register read in the very cycle that the eighth AIS pointer's second byte is accepted. The check passes only if that read returns 0 and a following read returns the AIS bit set, so the new edge was not swallowed by the clear.

// File: rtl/tu12_ptr_pkg.sv
package tu12_ptr_pkg;
  typedef enum logic [1:0] {
    PC_VALID = 2'd0,
    PC_AIS   = 2'd1,
    PC_INV   = 2'd2
  } ptr_cls_t;

  typedef enum logic [1:0] {
    ST_NORM = 2'd0,
    ST_AIS  = 2'd1,
    ST_LOP  = 2'd2
  } mon_st_t;

  localparam logic [1:0] ADDR_STATUS = 2'd0;
  localparam logic [1:0] ADDR_STICKY = 2'd1;
  localparam logic [1:0] ADDR_ENABLE = 2'd2;
endpackage

// File: rtl/tu12_ptr_classify.sv
module tu12_ptr_classify
  import tu12_ptr_pkg::*;
#(
  parameter int unsigned MAX_OFFSET = 139,
  parameter logic [3:0]  NDF_NORMAL = 4'b0110
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     beat,
  input  logic [7:0] data,
  input  logic     mark_v1,
  input  logic     mark_v2,
  output logic     evt_valid,
  output ptr_cls_t evt_cls
);
  logic [7:0]  v1_q;
  logic        v1_seen_q;
  logic [15:0] word;
  logic        unused_ss;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1_q      <= '0;
      v1_seen_q <= 1'b0;
    end else if (beat && mark_v1) begin
      v1_q      <= data;
      v1_seen_q <= 1'b1;
    end else if (evt_valid) begin
      v1_seen_q <= 1'b0;
    end
  end

  assign word      = {v1_q, data};
  assign unused_ss = ^word[11:10];
  assign evt_valid = beat && mark_v2 && !mark_v1 && v1_seen_q;

  always_comb begin
    if (word == 16'hFFFF)
      evt_cls = PC_AIS;
    else if (word[15:12] == NDF_NORMAL && 32'(word[9:0]) <= MAX_OFFSET)
      evt_cls = PC_VALID;
    else
      evt_cls = PC_INV;
  end

  AST_EVT_AFTER_V1: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |=> !v1_seen_q || $past(beat && mark_v1)); // R11
endmodule

// File: rtl/tu12_ptr_fsm.sv
module tu12_ptr_fsm
  import tu12_ptr_pkg::*;
#(
  parameter int unsigned PERSIST = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     evt_valid,
  input  ptr_cls_t evt_cls,
  output logic     ais_q,
  output logic     lop_q,
  output logic     ais_rise,
  output logic     lop_rise
);
  localparam int unsigned CW = $clog2(PERSIST + 1);
  localparam logic [CW-1:0] CMAX = CW'(PERSIST);

  mon_st_t st_q, st_d;
  logic [CW-1:0] cnt_q [3];
  logic [CW-1:0] cnt_d [3];

  for (genvar g = 0; g < 3; g++) begin : g_run
    always_comb begin
      cnt_d[g] = cnt_q[g];
      if (evt_valid) begin
        if (evt_cls == ptr_cls_t'(g))
          cnt_d[g] = (cnt_q[g] == CMAX) ? CMAX : cnt_q[g] + 1'b1;
        else
          cnt_d[g] = '0;
      end
    end
    always_ff @(posedge clk) begin
      if (!rst_n) cnt_q[g] <= '0;
      else        cnt_q[g] <= cnt_d[g];
    end
  end

  always_comb begin
    st_d = st_q;
    if (evt_valid) begin
      unique case (st_q)
        ST_NORM: if (cnt_d[PC_INV] == CMAX) st_d = ST_LOP;
                 else if (cnt_d[PC_AIS] == CMAX) st_d = ST_AIS;
        ST_AIS:  if (cnt_d[PC_INV] == CMAX) st_d = ST_LOP;
                 else if (cnt_d[PC_VALID] == CMAX) st_d = ST_NORM;
        ST_LOP:  if (cnt_d[PC_VALID] == CMAX) st_d = ST_NORM;
                 else if (cnt_d[PC_AIS] == CMAX) st_d = ST_AIS;
        default: st_d = ST_NORM;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_NORM;
    else        st_q <= st_d;
  end

  assign ais_q    = (st_q == ST_AIS);
  assign lop_q    = (st_q == ST_LOP);
  assign ais_rise = (st_d == ST_AIS) && (st_q != ST_AIS);
  assign lop_rise = (st_d == ST_LOP) && (st_q != ST_LOP);

  AST_AIS_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ais_q) |-> $past(evt_valid && evt_cls == PC_AIS)); // R3
  AST_LOP_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lop_q) |-> $past(evt_valid && evt_cls == PC_INV)); // R4
  AST_LOP_EXIT_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lop_q) |-> $past(evt_valid && evt_cls != PC_INV)); // R5
  AST_HOLD_NO_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_valid |=> $stable({ais_q, lop_q})); // R7
  AST_ONE_ALARM: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ais_q, lop_q})); // R6
endmodule

// File: rtl/tu12_ptr_regs.sv
module tu12_ptr_regs
  import tu12_ptr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ais_q,
  input  logic       lop_q,
  input  logic       ais_rise,
  input  logic       lop_rise,
  input  logic       reg_en,
  input  logic       reg_we,
  input  logic [1:0] reg_addr,
  input  logic [1:0] reg_wdata,
  output logic [1:0] reg_rdata,
  output logic       irq
);
  logic [1:0] sticky_q, en_q;
  logic       rd_sticky;

  assign rd_sticky = reg_en && !reg_we && (reg_addr == ADDR_STICKY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sticky_q <= '0;
      en_q     <= '0;
    end else begin
      sticky_q <= (sticky_q & ~{2{rd_sticky}}) | {lop_rise, ais_rise};
      if (reg_en && reg_we && reg_addr == ADDR_ENABLE)
        en_q <= reg_wdata;
    end
  end

  always_comb begin
    unique case (reg_addr)
      ADDR_STATUS: reg_rdata = {lop_q, ais_q};
      ADDR_STICKY: reg_rdata = sticky_q;
      ADDR_ENABLE: reg_rdata = en_q;
      default:     reg_rdata = '0;
    endcase
  end

  assign irq = |(sticky_q & en_q);

  AST_STICKY_FROM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sticky_q[0]) |-> $rose(ais_q)); // R8
  AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sticky && !ais_rise && !lop_rise) |=> sticky_q == 2'b00); // R8
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ais_rise && rd_sticky) |=> sticky_q[0]); // R9
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == 2'b00) |-> !irq); // R10
endmodule

// File: rtl/tu12_ptr_mon.sv
module tu12_ptr_mon
  import tu12_ptr_pkg::*;
#(
  parameter int unsigned PERSIST    = 8,
  parameter int unsigned MAX_OFFSET = 139,
  parameter logic [3:0]  NDF_NORMAL = 4'b0110
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_mark_v1,
  input  logic       in_mark_v2,
  input  logic       reg_en,
  input  logic       reg_we,
  input  logic [1:0] reg_addr,
  input  logic [1:0] reg_wdata,
  output logic [1:0] reg_rdata,
  output logic       irq
);
  logic     rdy_q;
  logic     beat;
  logic     evt_valid;
  ptr_cls_t evt_cls;
  logic     ais_q, lop_q, ais_rise, lop_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end

  assign in_ready = rdy_q;
  assign beat     = in_valid && rdy_q;

  tu12_ptr_classify #(
    .MAX_OFFSET(MAX_OFFSET),
    .NDF_NORMAL(NDF_NORMAL)
  ) u_cls (
    .clk(clk), .rst_n(rst_n), .beat(beat), .data(in_data),
    .mark_v1(in_mark_v1), .mark_v2(in_mark_v2),
    .evt_valid(evt_valid), .evt_cls(evt_cls)
  );

  tu12_ptr_fsm #(.PERSIST(PERSIST)) u_fsm (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_cls(evt_cls),
    .ais_q(ais_q), .lop_q(lop_q), .ais_rise(ais_rise), .lop_rise(lop_rise)
  );

  tu12_ptr_regs u_regs (
    .clk(clk), .rst_n(rst_n), .ais_q(ais_q), .lop_q(lop_q),
    .ais_rise(ais_rise), .lop_rise(lop_rise),
    .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  AST_READY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> in_ready); // R1
endmodule

// File: tb/tu12_ptr_mon_tb_top.sv
module tu12_ptr_mon_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [7:0] in_data = '0;
  logic in_mark_v1 = 1'b0, in_mark_v2 = 1'b0;
  logic reg_en = 1'b0, reg_we = 1'b0;
  logic [1:0] reg_addr = '0, reg_wdata = '0;
  logic [1:0] reg_rdata;
  logic irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tu12_ptr_mon dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_mark_v1(in_mark_v1), .in_mark_v2(in_mark_v2),
    .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // {first byte, second byte, multiframe count, expected status {lop,ais}}
  localparam int NV = 15;
  localparam logic [31:0] VEC [NV] = '{
    {8'h60, 8'h32, 8'd3, 8'h00},  // R2 valid offset 50
    {8'hFF, 8'hFF, 8'd7, 8'h00},  // R3 one short
    {8'hFF, 8'hFF, 8'd1, 8'h01},  // R3 eighth AIS
    {8'h60, 8'h05, 8'd7, 8'h01},  // R6 one short
    {8'h60, 8'h05, 8'd1, 8'h00},  // R6 back to normal
    {8'h60, 8'h8C, 8'd7, 8'h00},  // R2 offset 140 invalid
    {8'hFF, 8'hFF, 8'd1, 8'h00},  // R7 run broken
    {8'h90, 8'h10, 8'd7, 8'h00},  // R2 bad flag invalid
    {8'h61, 8'h00, 8'd1, 8'h02},  // R4 offset 256, eighth invalid
    {8'h60, 8'h8B, 8'd7, 8'h02},  // R5 offset 139 valid, one short
    {8'hFF, 8'hFF, 8'd1, 8'h02},  // R7 breaks valid run
    {8'hFF, 8'hFF, 8'd6, 8'h02},  // R5
    {8'hFF, 8'hFF, 8'd1, 8'h01},  // R5 LOP to AIS
    {8'h90, 8'h10, 8'd8, 8'h02},  // R4 AIS to LOP
    {8'h6C, 8'h00, 8'd8, 8'h00}   // R2 size bits ignored, R5 exit
  };

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic beat(input logic [7:0] d, input logic m1, input logic m2, input logic v);
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0;
    in_data = d; in_mark_v1 = m1; in_mark_v2 = m2; in_valid = v;
  endtask

  task automatic mframe(input logic [7:0] b1, input logic [7:0] b2, input logic b1_vld);
    beat(b1, 1'b1, 1'b0, b1_vld);
    beat(8'h00, 1'b0, 1'b0, 1'b1);
    beat(b2, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic rd(input logic [1:0] a, output logic [1:0] v);
    @(negedge clk);
    in_valid = 1'b0; in_mark_v1 = 1'b0; in_mark_v2 = 1'b0;
    reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_en = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [1:0] d);
    @(negedge clk);
    in_valid = 1'b0;
    reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [1:0] v;
    repeat (3) @(posedge clk);
    #1 chk("R1 ready in reset", {1'b0, in_ready}, 2'b00);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready", {1'b0, in_ready}, 2'b01);
    chk("R1 irq", {1'b0, irq}, 2'b00);
    rd(2'd0, v); chk("R1 status", v, 2'b00);
    rd(2'd1, v); chk("R1 sticky", v, 2'b00);
    rd(2'd2, v); chk("R1 enable", v, 2'b00);

    for (int i = 0; i < NV; i++) begin
      for (int k = 0; k < int'(VEC[i][15:8]); k++)
        mframe(VEC[i][31:24], VEC[i][23:16], 1'b1);
      rd(2'd0, v);
      chk($sformatf("R2-table row %0d", i), v, VEC[i][1:0]);
    end

    // R8 both alarms rose during the table; read clears
    rd(2'd1, v); chk("R8 sticky both", v, 2'b11);
    rd(2'd1, v); chk("R8 cleared", v, 2'b00);
    for (int k = 0; k < 8; k++) mframe(8'hFF, 8'hFF, 1'b1);
    chk("R10 irq masked", {1'b0, irq}, 2'b00);
    wr(2'd2, 2'b01);
    chk("R10 irq enabled", {1'b0, irq}, 2'b01);
    rd(2'd2, v); chk("R10 enable readback", v, 2'b01);
    wr(2'd0, 2'b10);
    wr(2'd1, 2'b10);
    rd(2'd0, v); chk("R10 status write ignored", v, 2'b01);
    rd(2'd1, v); chk("R8 AIS sticky", v, 2'b01);
    chk("R10 irq after clear", {1'b0, irq}, 2'b00);
    mframe(8'hFF, 8'hFF, 1'b1);
    rd(2'd1, v); chk("R8 no re-set while active", v, 2'b00);

    // R9 alarm edge coincides with sticky read
    for (int k = 0; k < 8; k++) mframe(8'h60, 8'h00, 1'b1);
    rd(2'd0, v); chk("R6 normal again", v, 2'b00);
    for (int k = 0; k < 7; k++) mframe(8'hFF, 8'hFF, 1'b1);
    beat(8'hFF, 1'b1, 1'b0, 1'b1);
    beat(8'h00, 1'b0, 1'b0, 1'b1);
    beat(8'hFF, 1'b0, 1'b1, 1'b1);
    reg_en = 1'b1; reg_we = 1'b0; reg_addr = 2'd1;
    #1 chk("R9 read returns old", reg_rdata, 2'b00);
    @(negedge clk);
    in_valid = 1'b0; reg_en = 1'b0;
    chk("R10 irq from coincident set", {1'b0, irq}, 2'b01);
    rd(2'd1, v); chk("R9 set wins", v, 2'b01);

    // R11 unaccepted first byte: second byte must be ignored
    for (int k = 0; k < 8; k++) mframe(8'h90, 8'h10, 1'b0);
    rd(2'd0, v); chk("R11 orphan second byte ignored", v, 2'b01);
    for (int k = 0; k < 8; k++) mframe(8'h90, 8'h10, 1'b1);
    rd(2'd0, v); chk("R11 accepted pairs count", v, 2'b10);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule